// File: doc/BRIEF.md
# ECC Error Status Capture Register

This block is the error-status register of a memory controller. The datapath reports error events to it: a correctable single-bit error, an uncorrectable multi-bit error, or a parity error. Each event comes with the physical address that failed, the ECC/parity mode in force, the data-bus width and the syndrome. The register keeps the details of the first error that matters and shows them in one 64-bit word that software reads.

Capture follows priority locking. Once a multi-bit error is recorded, every field is frozen. A recorded single-bit error stops only later single-bit errors from overwriting it, so a later multi-bit error still replaces it. Software writes ones to the two flag bits to clear them, and clearing a flag re-arms capture.

Top module: `ecc_err_capture`

## Requirements
- R1: The read word places the fields as follows. Address is in bits 63:28 and mode in bits 26:24. The width flag is bit 21 and the syndrome is bits 15:8. The multi-bit flag is bit 1 and the single-bit flag is bit 0. Every other bit reads 0.
- R2: The width flag holds the captured `evt_narrow` value: 1 means a 32-bit data bus and 0 means a 64-bit data bus.
- R3: A multi-bit strobe sets bit 1 one cycle later and captures all fields. A parity strobe does the same, but only while `parity_mode_on` is 1. A parity strobe with `parity_mode_on` at 0 changes nothing.
- R4: A single-bit strobe sets bit 0 one cycle later and captures all fields, provided no flag is holding.
- R5: While bit 1 is set and not being cleared, no strobe of any kind changes any field or flag.
- R6: While only bit 0 is set, later single-bit strobes are ignored. A multi-bit strobe still overwrites all fields and sets bit 1, and bit 0 stays 1.
- R7: A write with bit 1 of `wr_data` at 1 clears the multi-bit flag. A write with bit 0 at 1 clears the single-bit flag. Zero bits in the write, and all other bits, have no effect. Fields keep their values until the next capture.
- R8: When a clear and an allowed new event fall in the same cycle, the event wins. The flag stays set and the fields take the new values.
- R9: When single-bit and multi-bit strobes arrive together, the multi-bit capture is taken. Bit 1 is set and bit 0 is left unchanged.
- R10: Reset sets both flags to 0. The captured fields have no reset value.
- R11: After the flags are cleared, the next allowed error loads fresh address, mode, width and syndrome values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_single | input | 1 | Correctable single-bit error strobe |
| evt_multi | input | 1 | Uncorrectable multi-bit error strobe |
| evt_parity | input | 1 | Parity error strobe |
| parity_mode_on | input | 1 | Parity checking is the active protection mode |
| evt_addr | input | 36 | Physical address of the failing access |
| evt_mode | input | 3 | ECC/parity mode in force |
| evt_narrow | input | 1 | 1 = 32-bit data bus, 0 = 64-bit data bus |
| evt_synd | input | 8 | Syndrome of the failing access |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 64 | Write data (bits 1 and 0 clear on 1) |
| rd_data | output | 64 | Register read view |

## Verification
The assertions take the error strobes and the write strobe to be single-cycle, synchronous to `clk`, and free of X once reset is released. They also treat a parity strobe as meaningful only together with `parity_mode_on`. The stimulus changes inputs on the falling edge only and holds each strobe for exactly one cycle. It returns every strobe and `wr_en` to 0 between scenarios, and it drives the address, mode, width and syndrome with defined values whenever a strobe is raised.

// File: rtl/ecc_cap_pkg.sv
package ecc_cap_pkg;
  localparam int REG_W     = 64;
  localparam int ADDR_W    = 36;
  localparam int MODE_W    = 3;
  localparam int SYND_W    = 8;
  localparam int NFLAG     = 2;
  localparam int ADDR_LSB  = REG_W - ADDR_W;
  localparam int MODE_LSB  = 24;
  localparam int WIDTH_BIT = 21;
  localparam int SYND_LSB  = 8;
  localparam int MB_BIT    = 1;
  localparam int SB_BIT    = 0;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [MODE_W-1:0] mode;
    logic              narrow;
    logic [SYND_W-1:0] synd;
  } cap_rec_t;

  typedef enum logic [1:0] {
    CAP_NONE   = 2'd0,
    CAP_SINGLE = 2'd1,
    CAP_MULTI  = 2'd2
  } cap_kind_t;
endpackage

// File: rtl/ecc_cap_arbiter.sv
module ecc_cap_arbiter
  import ecc_cap_pkg::*;
(
  input  logic      evt_single,
  input  logic      evt_multi,
  input  logic      evt_parity,
  input  logic      parity_mode_on,
  input  logic      mb_hold,
  input  logic      sb_hold,
  output cap_kind_t kind
);
  logic multi_evt;

  always_comb begin
    multi_evt = evt_multi | (evt_parity & parity_mode_on);
    kind      = CAP_NONE;
    if (!mb_hold) begin
      if (multi_evt) begin
        kind = CAP_MULTI;
      end else if (evt_single && !sb_hold) begin
        kind = CAP_SINGLE;
      end
    end
  end
endmodule

// File: rtl/ecc_cap_flags.sv
module ecc_cap_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] set,
  output logic [N-1:0] flag_q,
  output logic [N-1:0] hold
);
  logic [N-1:0] flag_d;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_comb begin
      hold[i]   = flag_q[i] & ~clr[i];
      flag_d[i] = set[i] | hold[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q[i] <= 1'b0;
      else        flag_q[i] <= flag_d[i];
    end
  end
endmodule

// File: rtl/ecc_cap_store.sv
module ecc_cap_store
  import ecc_cap_pkg::*;
(
  input  logic     clk,
  input  logic     load,
  input  cap_rec_t d,
  output cap_rec_t q
);
  cap_rec_t rec_d;

  always_comb begin
    rec_d = q;
    if (load) rec_d = d;
  end

  always_ff @(posedge clk) begin
    q <= rec_d;
  end
endmodule

// File: rtl/ecc_err_capture.sv
module ecc_err_capture
  import ecc_cap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_single,
  input  logic              evt_multi,
  input  logic              evt_parity,
  input  logic              parity_mode_on,
  input  logic [ADDR_W-1:0] evt_addr,
  input  logic [MODE_W-1:0] evt_mode,
  input  logic              evt_narrow,
  input  logic [SYND_W-1:0] evt_synd,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  output logic [REG_W-1:0]  rd_data
);
  logic [NFLAG-1:0] clr;
  logic [NFLAG-1:0] set;
  logic [NFLAG-1:0] flag_q;
  logic [NFLAG-1:0] hold;
  cap_kind_t        kind;
  cap_rec_t         rec_in;
  cap_rec_t         rec_q;
  logic             load;

  always_comb begin
    clr         = '0;
    clr[MB_BIT] = wr_en & wr_data[MB_BIT];
    clr[SB_BIT] = wr_en & wr_data[SB_BIT];
  end

  ecc_cap_arbiter u_arb (
    .evt_single     (evt_single),
    .evt_multi      (evt_multi),
    .evt_parity     (evt_parity),
    .parity_mode_on (parity_mode_on),
    .mb_hold        (hold[MB_BIT]),
    .sb_hold        (hold[SB_BIT]),
    .kind           (kind)
  );

  always_comb begin
    set         = '0;
    set[MB_BIT] = (kind == CAP_MULTI);
    set[SB_BIT] = (kind == CAP_SINGLE);
    load        = (kind != CAP_NONE);
    rec_in      = '{addr: evt_addr, mode: evt_mode, narrow: evt_narrow, synd: evt_synd};
  end

  ecc_cap_flags #(.N(NFLAG)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (clr),
    .set    (set),
    .flag_q (flag_q),
    .hold   (hold)
  );

  ecc_cap_store u_store (
    .clk  (clk),
    .load (load),
    .d    (rec_in),
    .q    (rec_q)
  );

  always_comb begin
    rd_data                              = '0;
    rd_data[ADDR_LSB +: ADDR_W]          = rec_q.addr;
    rd_data[MODE_LSB +: MODE_W]          = rec_q.mode;
    rd_data[WIDTH_BIT]                   = rec_q.narrow;
    rd_data[SYND_LSB +: SYND_W]          = rec_q.synd;
    rd_data[MB_BIT]                      = flag_q[MB_BIT];
    rd_data[SB_BIT]                      = flag_q[SB_BIT];
  end
endmodule

// File: rtl/ecc_err_capture_chk.sv
module ecc_err_capture_chk
  import ecc_cap_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             evt_single,
  input logic             evt_multi,
  input logic             evt_parity,
  input logic             parity_mode_on,
  input logic             wr_en,
  input logic [REG_W-1:0] wr_data,
  input logic [REG_W-1:0] rd_data
);
  logic multi_in;
  assign multi_in = evt_multi | (evt_parity & parity_mode_on);

  // R5: a held multi-bit record is frozen
  assert_mb_freeze_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[MB_BIT] && !(wr_en && wr_data[MB_BIT])
    |=> $stable(rd_data[REG_W-1:2]) && rd_data[MB_BIT]);

  // R6: a held single-bit record ignores single-bit strobes
  assert_sb_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[SB_BIT] && !rd_data[MB_BIT] && !(wr_en && wr_data[SB_BIT]) && !multi_in
    |=> $stable(rd_data[REG_W-1:2]) && rd_data[SB_BIT]);

  // R3: a multi-bit class event always leaves the multi-bit flag set
  assert_mb_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    multi_in |=> rd_data[MB_BIT]);

  // R4: a single-bit strobe leaves some flag set
  assert_sb_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    evt_single |=> rd_data[SB_BIT] || rd_data[MB_BIT]);

  // R7: clearing with no competing event drops the flag
  assert_sb_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_data[SB_BIT] && !evt_single |=> !rd_data[SB_BIT]);

  assert_mb_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_data[MB_BIT] && !multi_in |=> !rd_data[MB_BIT]);
endmodule

bind ecc_err_capture ecc_err_capture_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .evt_single     (evt_single),
  .evt_multi      (evt_multi),
  .evt_parity     (evt_parity),
  .parity_mode_on (parity_mode_on),
  .wr_en          (wr_en),
  .wr_data        (wr_data),
  .rd_data        (rd_data)
);

// File: tb/ecc_err_capture_test.sv
module ecc_err_capture_test;
  logic        clk;
  logic        rst_n;
  logic        evt_single, evt_multi, evt_parity, parity_mode_on;
  logic [35:0] evt_addr;
  logic [2:0]  evt_mode;
  logic        evt_narrow;
  logic [7:0]  evt_synd;
  logic        wr_en;
  logic [63:0] wr_data;
  logic [63:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  localparam logic [63:0] USED_MASK = 64'hFFFF_FFFF_F720_FF03;

  ecc_err_capture uut (
    .clk(clk), .rst_n(rst_n), .evt_single(evt_single), .evt_multi(evt_multi),
    .evt_parity(evt_parity), .parity_mode_on(parity_mode_on), .evt_addr(evt_addr),
    .evt_mode(evt_mode), .evt_narrow(evt_narrow), .evt_synd(evt_synd),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [63:0] mk(logic [35:0] a, logic [2:0] m, logic n,
                                     logic [7:0] s, logic mb, logic sb);
    logic [63:0] w;
    w = '0;
    w[63:28] = a;
    w[26:24] = m;
    w[21]    = n;
    w[15:8]  = s;
    w[1]     = mb;
    w[0]     = sb;
    return w;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive_idle();
    evt_single = 0; evt_multi = 0; evt_parity = 0; parity_mode_on = 0;
    evt_addr = '0; evt_mode = '0; evt_narrow = 0; evt_synd = '0;
    wr_en = 0; wr_data = '0;
  endtask

  task automatic step(logic sb, logic mb, logic par, logic pon, logic [35:0] a,
                      logic [2:0] m, logic n, logic [7:0] s, logic we, logic [1:0] wb);
    @(negedge clk);
    evt_single = sb; evt_multi = mb; evt_parity = par; parity_mode_on = pon;
    evt_addr = a; evt_mode = m; evt_narrow = n; evt_synd = s;
    wr_en = we; wr_data = {~62'd0, wb};
    @(negedge clk);
    drive_idle();
  endtask

  task automatic clear_all();
    step(0, 0, 0, 0, '0, '0, 0, '0, 1, 2'b11);
  endtask

  task automatic t_reset();
    chk("R10 flags after reset", {62'd0, rd_data[1:0]}, 64'd0);
  endtask

  task automatic t_single();
    clear_all();
    step(1, 0, 0, 0, 36'h1_2345_6789, 3'd2, 0, 8'h5A, 0, 2'b00);
    chk("R4 single capture", rd_data, mk(36'h1_2345_6789, 3'd2, 0, 8'h5A, 0, 1));
    chk("R1 reserved bits zero", rd_data & ~USED_MASK, 64'd0);
  endtask

  task automatic t_sb_lock();
    step(1, 0, 0, 0, 36'hA_AAAA_AAAA, 3'd5, 1, 8'h11, 0, 2'b00);
    chk("R6 second single ignored", rd_data, mk(36'h1_2345_6789, 3'd2, 0, 8'h5A, 0, 1));
    step(0, 1, 0, 0, 36'hF_0000_000F, 3'd1, 1, 8'hC3, 0, 2'b00);
    chk("R6 multi overrides single", rd_data, mk(36'hF_0000_000F, 3'd1, 1, 8'hC3, 1, 1));
  endtask

  task automatic t_mb_freeze();
    step(0, 1, 0, 0, 36'h0_0BAD_BEEF, 3'd7, 0, 8'hEE, 0, 2'b00);
    chk("R5 multi ignored while multi held", rd_data, mk(36'hF_0000_000F, 3'd1, 1, 8'hC3, 1, 1));
    step(1, 0, 0, 0, 36'h0_1111_2222, 3'd3, 0, 8'h22, 0, 2'b00);
    chk("R5 single ignored while multi held", rd_data, mk(36'hF_0000_000F, 3'd1, 1, 8'hC3, 1, 1));
    step(0, 0, 1, 1, 36'h0_3333_4444, 3'd4, 0, 8'h44, 0, 2'b00);
    chk("R5 parity ignored while multi held", rd_data, mk(36'hF_0000_000F, 3'd1, 1, 8'hC3, 1, 1));
  endtask

  task automatic t_clear();
    step(0, 0, 0, 0, '0, '0, 0, '0, 1, 2'b01);
    chk("R7 clear single only", rd_data, mk(36'hF_0000_000F, 3'd1, 1, 8'hC3, 1, 0));
    step(0, 0, 0, 0, '0, '0, 0, '0, 1, 2'b00);
    chk("R7 zero write no effect", rd_data, mk(36'hF_0000_000F, 3'd1, 1, 8'hC3, 1, 0));
    step(0, 0, 0, 0, '0, '0, 0, '0, 1, 2'b10);
    chk("R7 clear multi", rd_data, mk(36'hF_0000_000F, 3'd1, 1, 8'hC3, 0, 0));
  endtask

  task automatic t_rearm();
    step(1, 0, 0, 0, 36'h5_5555_0001, 3'd6, 0, 8'h77, 0, 2'b00);
    chk("R11 fresh capture after clear", rd_data, mk(36'h5_5555_0001, 3'd6, 0, 8'h77, 0, 1));
  endtask

  task automatic t_parity();
    clear_all();
    step(0, 0, 1, 0, 36'h6_0000_0006, 3'd4, 0, 8'h66, 0, 2'b00);
    chk("R3 parity outside parity mode ignored", {62'd0, rd_data[1:0]}, 64'd0);
    step(0, 0, 1, 1, 36'h6_0000_0006, 3'd4, 0, 8'h66, 0, 2'b00);
    chk("R3 parity in parity mode", rd_data, mk(36'h6_0000_0006, 3'd4, 0, 8'h66, 1, 0));
  endtask

  task automatic t_width();
    clear_all();
    step(0, 1, 0, 0, 36'h7_0000_0007, 3'd0, 1, 8'h01, 0, 2'b00);
    chk("R2 narrow bus flag one", {63'd0, rd_data[21]}, 64'd1);
    clear_all();
    step(1, 0, 0, 0, 36'h7_0000_0008, 3'd0, 0, 8'h02, 0, 2'b00);
    chk("R2 wide bus flag zero", {63'd0, rd_data[21]}, 64'd0);
  endtask

  task automatic t_collide();
    step(1, 0, 0, 0, 36'h8_1234_0000, 3'd3, 1, 8'h88, 1, 2'b01);
    chk("R8 single wins over clear", rd_data, mk(36'h8_1234_0000, 3'd3, 1, 8'h88, 0, 1));
    step(0, 1, 0, 0, 36'h8_0000_4321, 3'd2, 0, 8'h99, 0, 2'b00);
    step(0, 1, 0, 0, 36'h9_9999_9999, 3'd5, 1, 8'hAB, 1, 2'b10);
    chk("R8 multi wins over clear", rd_data, mk(36'h9_9999_9999, 3'd5, 1, 8'hAB, 1, 1));
  endtask

  task automatic t_simul();
    clear_all();
    step(1, 1, 0, 0, 36'hC_0FFE_E000, 3'd6, 1, 8'h3C, 0, 2'b00);
    chk("R9 simultaneous takes multi", rd_data, mk(36'hC_0FFE_E000, 3'd6, 1, 8'h3C, 1, 0));
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    drive_idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_sb_lock();
    t_mb_freeze();
    t_clear();
    t_rearm();
    t_parity();
    t_width();
    t_collide();
    t_simul();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule